// File: doc/BRIEF.md
# RAID P/Q Parity Engine

This block produces the two redundancy streams of a dual-parity disk array from a set of up to 32 equal-length data buffers. The buffers are presented as interleaved 64-bit beats: for each 8-byte offset of the stream, one beat arrives for every buffer, in buffer order. Each beat arrives with three side fields: a flag that adds it to the plain parity (P), a flag that adds it to the weighted parity (Q), and an 8-bit weight for Q. P is the bitwise XOR of the participating bytes. Q XORs together the participating bytes after each is multiplied in GF(2^8) by its buffer's weight. The reduction polynomial of that field can be reprogrammed.

An instruction starts with a one-cycle `start` pulse that latches the buffer count, the stream length in beats and the mode bits. Either result can be folded into the other (cross-XOR). Either pipe can also be switched to a search mode. In search mode the pipe sends no data. It reports only the byte position of the first non-zero byte in its result stream. A pulse on `done` follows the last output beat of every instruction.

Top module: `raid_pq_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `p_valid`, `q_valid` and `done` are low, and the polynomial register holds 8'h1D.
- R2: With P enabled and not in search mode, each P output beat equals the XOR of the same-offset beats of all buffers whose P flag is set. This holds for 1 to 32 buffers.
- R3: With Q enabled and not in search mode, each byte of a Q output beat equals the XOR, over buffers with the Q flag set, of that byte multiplied in GF(2^8) by the buffer's weight. A weight of 1 is the identity, so Q then equals plain XOR.
- R4: A `poly_wr` pulse loads `poly_val` as the low 8 bits of the reduction polynomial (x^8 implied). Every later instruction multiplies with the new polynomial.
- R5: With `cfg_p_xor` set, each P output beat is the P result XOR the Q result. With `cfg_q_xor` set, each Q output beat is the Q result XOR the P result.
- R6: A pipe in search mode emits exactly one beat, in the cycle after the final input beat. The beat is the zero-extended byte position (beat index × 8 + lane) of the first non-zero byte of that pipe's result. Lane 0 is bits 7:0 and is searched first. If no byte is non-zero, the beat is all ones.
- R7: An output beat is valid in the cycle after the last buffer's beat of its offset is accepted. `done` pulses for one cycle, in the cycle after the last output beat. At least one pipe must be enabled.
- R8: Each instruction starts from cleared accumulators, so its results do not depend on earlier instructions.
- R9: `in_valid` beats presented while no instruction is active are ignored and produce no output.
- R10: A pipe whose enable bit is clear emits no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poly_wr | input | 1 | Load the reduction polynomial |
| poly_val | input | 8 | Polynomial low 8 bits |
| start | input | 1 | Begin an instruction (ignored while busy) |
| cfg_nbuf | input | 6 | Buffer count, 1 to 32 |
| cfg_nbeat | input | 21 | Stream length in 8-byte beats, at least 1 |
| cfg_p_en | input | 1 | Enable the P pipe |
| cfg_q_en | input | 1 | Enable the Q pipe |
| cfg_p_xor | input | 1 | Fold Q into the P output |
| cfg_q_xor | input | 1 | Fold P into the Q output |
| cfg_p_cmp | input | 1 | P pipe in search mode |
| cfg_q_cmp | input | 1 | Q pipe in search mode |
| in_valid | input | 1 | Input beat present |
| in_data | input | 64 | Input beat |
| in_p_en | input | 1 | This buffer joins P |
| in_q_en | input | 1 | This buffer joins Q |
| in_mult | input | 8 | GF(2^8) weight of this buffer for Q |
| p_valid | output | 1 | P output beat valid |
| p_data | output | 64 | P output beat or search result |
| q_valid | output | 1 | Q output beat valid |
| q_data | output | 64 | Q output beat or search result |
| done | output | 1 | Instruction finished |

## Verification
The checker watches the control timing on every cycle. It checks that output beats occur only in the cycle after an offset completes, that no beat appears while idle or on a disabled pipe, and that `done` is a single pulse following an output beat. It also checks that a search-mode beat is the final one and is either a valid position or all ones. The arithmetic can only be shown by the bench's scenarios. These cover the P and Q values under random weights, identity weights, a reprogrammed polynomial, both cross-XOR modes, a search that hits a known byte and one that finds nothing, and back-to-back instructions.

// File: rtl/raid_pq_pkg.sv
package raid_pq_pkg;

  typedef struct packed {
    logic p_en;
    logic q_en;
    logic p_xor;
    logic q_xor;
    logic p_cmp;
    logic q_cmp;
  } pq_mode_t;

  // GF(2^8) product, most significant multiplier bit first, reduced by
  // x^8 + poly after every doubling.
  function automatic logic [7:0] gf_mul(input logic [7:0] a,
                                        input logic [7:0] b,
                                        input logic [7:0] poly);
    logic [7:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? poly : 8'h00);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

endpackage

// File: rtl/raid_pq_accum.sv
module raid_pq_accum #(
  parameter int BYTES = 8,
  parameter bit GF    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 load,
  input  logic                 first,
  input  logic                 en,
  input  logic [7:0]           mult,
  input  logic [7:0]           poly,
  input  logic [BYTES*8-1:0]   data,
  output logic [BYTES*8-1:0]   sum
);
  import raid_pq_pkg::*;
  localparam int DW = BYTES * 8;

  logic [DW-1:0] acc_q;
  logic [DW-1:0] term;

  generate
    if (GF) begin : g_weighted
      for (genvar l = 0; l < BYTES; l++) begin : g_lane
        assign term[l*8 +: 8] = en ? gf_mul(data[l*8 +: 8], mult, poly) : 8'h00;
      end
    end else begin : g_plain
      assign term = en ? data : '0;
    end
  endgenerate

  assign sum = (first ? '0 : acc_q) ^ term;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (load)  acc_q <= sum;
  end

endmodule

// File: rtl/raid_nz_detect.sv
module raid_nz_detect #(
  parameter int BYTES  = 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  logic [BYTES*8-1:0] data,
  output logic               hit,
  output logic [LANE_W-1:0]  lane
);
  // Lowest lane wins: scan downward so the last match is the lowest.
  always_comb begin
    hit  = 1'b0;
    lane = '0;
    for (int l = BYTES - 1; l >= 0; l--) begin
      if (data[l*8 +: 8] != 8'h00) begin
        hit  = 1'b1;
        lane = LANE_W'(l);
      end
    end
  end

endmodule

// File: rtl/raid_pq_locator.sv
module raid_pq_locator #(
  parameter int BYTES  = 8,
  parameter int BEAT_W = 21,
  localparam int DW     = BYTES * 8,
  localparam int LANE_W = $clog2(BYTES),
  localparam int POS_W  = BEAT_W + LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [DW-1:0]     data,
  input  logic [BEAT_W-1:0] beat,
  output logic [DW-1:0]     result
);
  logic              hit;
  logic [LANE_W-1:0] lane;
  logic              found_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  cur_pos;

  raid_nz_detect #(.BYTES(BYTES)) u_det (
    .data (data),
    .hit  (hit),
    .lane (lane)
  );

  assign cur_pos = {beat, lane};

  always_comb begin
    if (found_q)  result = {{(DW-POS_W){1'b0}}, pos_q};
    else if (hit) result = {{(DW-POS_W){1'b0}}, cur_pos};
    else          result = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      pos_q   <= '0;
    end else if (clear) begin
      found_q <= 1'b0;
      pos_q   <= '0;
    end else if (step && hit && !found_q) begin
      found_q <= 1'b1;
      pos_q   <= cur_pos;
    end
  end

endmodule

// File: rtl/raid_pq_engine.sv
module raid_pq_engine #(
  parameter int MAX_BUFS = 32,
  parameter int BYTES    = 8,
  parameter int LEN_W    = 24,
  localparam int DW      = BYTES * 8,
  localparam int LANE_W  = $clog2(BYTES),
  localparam int BEAT_W  = LEN_W - LANE_W,
  localparam int IDX_W   = $clog2(MAX_BUFS),
  localparam int CNT_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poly_wr,
  input  logic [7:0]        poly_val,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_nbuf,
  input  logic [BEAT_W-1:0] cfg_nbeat,
  input  logic              cfg_p_en,
  input  logic              cfg_q_en,
  input  logic              cfg_p_xor,
  input  logic              cfg_q_xor,
  input  logic              cfg_p_cmp,
  input  logic              cfg_q_cmp,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  input  logic              in_p_en,
  input  logic              in_q_en,
  input  logic [7:0]        in_mult,
  output logic              p_valid,
  output logic [DW-1:0]     p_data,
  output logic              q_valid,
  output logic [DW-1:0]     q_data,
  output logic              done
);
  import raid_pq_pkg::*;

  pq_mode_t          cfg_q;
  logic              busy_q;
  logic [CNT_W-1:0]  nbuf_q;
  logic [BEAT_W-1:0] nbeat_q;
  logic [IDX_W-1:0]  buf_idx_q;
  logic [BEAT_W-1:0] beat_idx_q;
  logic [7:0]        poly_q;

  // Named events used by the checker.
  logic launch;
  logic accept;
  logic first_buf;
  logic last_buf;
  logic last_beat;
  logic offset_end;
  logic instr_end;

  assign launch     = start && !busy_q;
  assign accept     = busy_q && in_valid;
  assign first_buf  = (buf_idx_q == '0);
  assign last_buf   = ({1'b0, buf_idx_q} + 1'b1) == nbuf_q;
  assign last_beat  = beat_idx_q == (nbeat_q - 1'b1);
  assign offset_end = accept && last_buf;
  assign instr_end  = offset_end && last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n)       poly_q <= 8'h1D;
    else if (poly_wr) poly_q <= poly_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cfg_q      <= '0;
      nbuf_q     <= '0;
      nbeat_q    <= '0;
      buf_idx_q  <= '0;
      beat_idx_q <= '0;
    end else if (launch) begin
      busy_q     <= 1'b1;
      cfg_q      <= '{p_en: cfg_p_en, q_en: cfg_q_en, p_xor: cfg_p_xor,
                      q_xor: cfg_q_xor, p_cmp: cfg_p_cmp, q_cmp: cfg_q_cmp};
      nbuf_q     <= cfg_nbuf;
      nbeat_q    <= cfg_nbeat;
      buf_idx_q  <= '0;
      beat_idx_q <= '0;
    end else if (accept) begin
      if (last_buf) begin
        buf_idx_q  <= '0;
        beat_idx_q <= beat_idx_q + 1'b1;
        if (last_beat) busy_q <= 1'b0;
      end else begin
        buf_idx_q <= buf_idx_q + 1'b1;
      end
    end
  end

  logic [DW-1:0] p_sum, q_sum, p_res, q_res, p_loc, q_loc;

  raid_pq_accum #(.BYTES(BYTES), .GF(1'b0)) u_pacc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .load(accept),
    .first(first_buf), .en(in_p_en), .mult(in_mult), .poly(poly_q),
    .data(in_data), .sum(p_sum)
  );

  raid_pq_accum #(.BYTES(BYTES), .GF(1'b1)) u_qacc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .load(accept),
    .first(first_buf), .en(in_q_en), .mult(in_mult), .poly(poly_q),
    .data(in_data), .sum(q_sum)
  );

  assign p_res = p_sum ^ (cfg_q.p_xor ? q_sum : '0);
  assign q_res = q_sum ^ (cfg_q.q_xor ? p_sum : '0);

  raid_pq_locator #(.BYTES(BYTES), .BEAT_W(BEAT_W)) u_ploc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .step(offset_end),
    .data(p_res), .beat(beat_idx_q), .result(p_loc)
  );

  raid_pq_locator #(.BYTES(BYTES), .BEAT_W(BEAT_W)) u_qloc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .step(offset_end),
    .data(q_res), .beat(beat_idx_q), .result(q_loc)
  );

  logic          p_valid_q, q_valid_q, tail_q, done_q;
  logic [DW-1:0] p_data_q, q_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid_q <= 1'b0;
      q_valid_q <= 1'b0;
      p_data_q  <= '0;
      q_data_q  <= '0;
      tail_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      p_valid_q <= offset_end && cfg_q.p_en && (!cfg_q.p_cmp || last_beat);
      q_valid_q <= offset_end && cfg_q.q_en && (!cfg_q.q_cmp || last_beat);
      if (offset_end) begin
        p_data_q <= cfg_q.p_cmp ? p_loc : p_res;
        q_data_q <= cfg_q.q_cmp ? q_loc : q_res;
      end
      tail_q <= instr_end;
      done_q <= tail_q;
    end
  end

  assign p_valid = p_valid_q;
  assign q_valid = q_valid_q;
  assign p_data  = p_data_q;
  assign q_data  = q_data_q;
  assign done    = done_q;

endmodule

// File: rtl/raid_pq_chk.sv
module raid_pq_chk #(
  parameter int DW    = 64,
  parameter int POS_W = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          offset_end,
  input logic          p_en,
  input logic          q_en,
  input logic          p_cmp,
  input logic          q_cmp,
  input logic          p_valid,
  input logic          q_valid,
  input logic [DW-1:0] p_data,
  input logic [DW-1:0] q_data,
  input logic          done
);

  // R7
  out_after_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid || q_valid) |-> $past(offset_end));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(p_valid || q_valid) && !busy));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !(p_valid || q_valid));

  // R10
  p_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> p_en);

  // R10
  q_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> q_en);

  // R6
  p_cmp_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_cmp) |=> done);

  // R6
  q_cmp_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_cmp) |=> done);

  // R6
  p_cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_cmp) |-> ((&p_data) || (p_data[DW-1:POS_W] == '0)));

  // R6
  q_cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_cmp) |-> ((&q_data) || (q_data[DW-1:POS_W] == '0)));

endmodule

bind raid_pq_engine raid_pq_chk #(.DW(DW), .POS_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_q),
  .offset_end (offset_end),
  .p_en       (cfg_q.p_en),
  .q_en       (cfg_q.q_en),
  .p_cmp      (cfg_q.p_cmp),
  .q_cmp      (cfg_q.q_cmp),
  .p_valid    (p_valid),
  .q_valid    (q_valid),
  .p_data     (p_data),
  .q_data     (q_data),
  .done       (done)
);

// File: tb/sim_raid_pq_engine.sv
module sim_raid_pq_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int NT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic poly_wr = 1'b0; logic [7:0] poly_val = '0;
  logic start = 1'b0; logic [5:0] cfg_nbuf = '0; logic [20:0] cfg_nbeat = '0;
  logic cfg_p_en = 0, cfg_q_en = 0, cfg_p_xor = 0, cfg_q_xor = 0, cfg_p_cmp = 0, cfg_q_cmp = 0;
  logic in_valid = 1'b0; logic [63:0] in_data = '0;
  logic in_p_en = 0, in_q_en = 0; logic [7:0] in_mult = '0;
  logic p_valid, q_valid, done; logic [63:0] p_data, q_data;

  raid_pq_engine u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_cyc = 0, done_cyc = -1, done_cnt = 0;
  logic [63:0] din [NB][NT];
  logic pen_a [NB]; logic qen_a [NB]; logic [7:0] mul_a [NB];
  logic [7:0] poly_ref = 8'h1D;
  logic [63:0] pq[$], qq[$]; int pcyc[$], qcyc[$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (p_valid) begin pq.push_back(p_data); pcyc.push_back(cyc); end
    if (q_valid) begin qq.push_back(q_data); qcyc.push_back(cyc); end
    if (done) begin done_cyc = cyc; done_cnt++; end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", rq, act, exp); end
  endtask

  // LSB-first multiply with doubling of the multiplicand.
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) r ^= a;
      a = a[7] ? ((a << 1) ^ poly_ref) : (a << 1);
      b = b >> 1;
    end
    return r;
  endfunction

  function automatic logic [63:0] raw_p(input int b, input int nb);
    logic [63:0] s = 0;
    for (int i = 0; i < nb; i++) if (pen_a[i]) s ^= din[i][b];
    return s;
  endfunction

  function automatic logic [63:0] raw_q(input int b, input int nb);
    logic [63:0] s = 0;
    for (int i = 0; i < nb; i++)
      if (qen_a[i]) for (int l = 0; l < 8; l++) s[l*8 +: 8] ^= ref_mul(din[i][b][l*8 +: 8], mul_a[i]);
    return s;
  endfunction

  task automatic fill(input int nb, input int nt);
    for (int i = 0; i < nb; i++) begin
      for (int b = 0; b < nt; b++) din[i][b] = {$urandom, $urandom};
      pen_a[i] = $urandom_range(0, 1); qen_a[i] = $urandom_range(0, 1);
      mul_a[i] = qen_a[i] ? 8'($urandom_range(1, 255)) : 8'h00;
    end
    pen_a[0] = 1'b1; qen_a[nb-1] = 1'b1; mul_a[nb-1] = 8'h8E;
  endtask

  task automatic run(input int nb, input int nt, input bit pe, qe, px, qx, pc, qc);
    pq.delete(); qq.delete(); pcyc.delete(); qcyc.delete(); done_cnt = 0; done_cyc = -1;
    @(posedge clk); #1;
    start = 1; cfg_nbuf = 6'(nb); cfg_nbeat = 21'(nt);
    cfg_p_en = pe; cfg_q_en = qe; cfg_p_xor = px; cfg_q_xor = qx; cfg_p_cmp = pc; cfg_q_cmp = qc;
    @(posedge clk); #1; start = 0;
    for (int b = 0; b < nt; b++)
      for (int i = 0; i < nb; i++) begin
        in_valid = 1; in_data = din[i][b]; in_p_en = pen_a[i]; in_q_en = qen_a[i]; in_mult = mul_a[i];
        @(posedge clk); #1;
      end
    in_valid = 0; last_cyc = cyc;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic verify(input int nb, input int nt, input bit pe, qe, px, qx, pc, qc, input string rq);
    logic [63:0] ep[NT], eq[NT], lp, lq;
    bit fp = 0, fq = 0;
    int np, nq;
    lp = '1; lq = '1;
    for (int b = 0; b < nt; b++) begin
      ep[b] = raw_p(b, nb) ^ (px ? raw_q(b, nb) : 64'h0);
      eq[b] = raw_q(b, nb) ^ (qx ? raw_p(b, nb) : 64'h0);
      for (int l = 0; l < 8; l++) begin
        if (!fp && ep[b][l*8 +: 8] != 0) begin fp = 1; lp = 64'(b*8 + l); end
        if (!fq && eq[b][l*8 +: 8] != 0) begin fq = 1; lq = 64'(b*8 + l); end
      end
    end
    np = pe ? (pc ? 1 : nt) : 0;
    nq = qe ? (qc ? 1 : nt) : 0;
    chk(pq.size() == np, {rq, " R10 P beat count"}, 64'(pq.size()), 64'(np));
    chk(qq.size() == nq, {rq, " R10 Q beat count"}, 64'(qq.size()), 64'(nq));
    if (pq.size() == np) for (int k = 0; k < np; k++) chk(pq[k] === (pc ? lp : ep[k]), {rq, " P beat"}, pq[k], pc ? lp : ep[k]);
    if (qq.size() == nq) for (int k = 0; k < nq; k++) chk(qq[k] === (qc ? lq : eq[k]), {rq, " Q beat"}, qq[k], qc ? lq : eq[k]);
    if (np > 0) chk(pcyc[np-1] == last_cyc, "R7 last P beat cycle", 64'(pcyc[np-1]), 64'(last_cyc));
    if (nq > 0) chk(qcyc[nq-1] == last_cyc, "R7 last Q beat cycle", 64'(qcyc[nq-1]), 64'(last_cyc));
    chk(done_cnt == 1 && done_cyc == last_cyc + 1, "R7 done pulse", 64'(done_cyc), 64'(last_cyc + 1));
  endtask

  task automatic t_reset();
    chk(!p_valid && !q_valid && !done, "R1 outputs in reset", {61'b0, p_valid, q_valid, done}, 64'h0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!p_valid && !q_valid && !done, "R1 outputs after reset", {61'b0, p_valid, q_valid, done}, 64'h0);
  endtask

  task automatic t_p_basic();
    fill(4, 3); pen_a[1] = 0; pen_a[2] = 1;
    run(4, 3, 1, 0, 0, 0, 0, 0); verify(4, 3, 1, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_q_mult();
    fill(5, 2);
    run(5, 2, 1, 1, 0, 0, 0, 0); verify(5, 2, 1, 1, 0, 0, 0, 0, "R3");
    fill(NB, 2);
    run(NB, 2, 1, 1, 0, 0, 0, 0); verify(NB, 2, 1, 1, 0, 0, 0, 0, "R2 R3 32 buffers");
  endtask

  task automatic t_identity();
    fill(6, 2);
    for (int i = 0; i < 6; i++) begin qen_a[i] = pen_a[i]; mul_a[i] = pen_a[i] ? 8'h01 : 8'h00; end
    run(6, 2, 1, 1, 0, 0, 0, 0);
    if (qq.size() == 2 && pq.size() == 2)
      for (int k = 0; k < 2; k++) chk(qq[k] === pq[k], "R3 identity weight", qq[k], pq[k]);
    else chk(0, "R3 identity beat count", 64'(qq.size()), 64'd2);
  endtask

  task automatic t_poly();
    @(posedge clk); #1; poly_wr = 1; poly_val = 8'h4D;
    @(posedge clk); #1; poly_wr = 0; poly_ref = 8'h4D;
    fill(3, 2); for (int i = 0; i < 3; i++) begin qen_a[i] = 1; mul_a[i] = 8'hF0 + 8'(i); end
    run(3, 2, 0, 1, 0, 0, 0, 0); verify(3, 2, 0, 1, 0, 0, 0, 0, "R4");
    @(posedge clk); #1; poly_wr = 1; poly_val = 8'h1D;
    @(posedge clk); #1; poly_wr = 0; poly_ref = 8'h1D;
  endtask

  task automatic t_xor();
    fill(4, 2);
    run(4, 2, 1, 1, 1, 0, 0, 0); verify(4, 2, 1, 1, 1, 0, 0, 0, "R5 P fold");
    run(4, 2, 1, 1, 0, 1, 0, 0); verify(4, 2, 1, 1, 0, 1, 0, 0, "R5 Q fold");
  endtask

  task automatic t_cmp();
    for (int i = 0; i < 3; i++) begin
      for (int b = 0; b < 3; b++) din[i][b] = '0;
      pen_a[i] = 0; qen_a[i] = 0; mul_a[i] = 0;
    end
    din[2][1][47:40] = 8'h40; din[2][2][7:0] = 8'h11;
    pen_a[2] = 1; qen_a[0] = 1; mul_a[0] = 8'h07;
    run(3, 3, 1, 1, 0, 0, 1, 1);
    chk(pq.size() == 1 && pq[0] === 64'd13, "R6 first hit position", pq.size() ? pq[0] : '0, 64'd13);
    chk(qq.size() == 1 && qq[0] === '1, "R6 no hit all ones", qq.size() ? qq[0] : '0, '1);
    verify(3, 3, 1, 1, 0, 0, 1, 1, "R6");
  endtask

  task automatic t_idle();
    pq.delete(); qq.delete(); done_cnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1; in_valid = 1; in_data = {$urandom, $urandom}; in_p_en = 1; in_q_en = 1; in_mult = 8'h03;
    end
    @(posedge clk); #1; in_valid = 0;
    repeat (3) @(posedge clk); #1;
    chk(pq.size() == 0 && qq.size() == 0 && done_cnt == 0, "R9 idle beats ignored",
        64'(pq.size() + qq.size() + done_cnt), 64'h0);
  endtask

  task automatic t_clear();
    fill(3, 2); run(3, 2, 1, 1, 0, 0, 0, 0);
    fill(2, 3); run(2, 3, 1, 1, 0, 0, 0, 0); verify(2, 3, 1, 1, 0, 0, 0, 0, "R8 second instruction");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_p_basic();
    t_q_mult();
    t_identity();
    t_poly();
    t_xor();
    t_cmp();
    t_idle();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule